// File: doc/BRIEF.md
# Clock Output Power-Down Sequencer

This block decides when the outputs of a multi-output clock generator stop and when they start again, so that no output ever shows a shortened pulse. One shared input pin has two roles. After reset it is a power-good strobe that is active low. Once it has been seen low, it becomes an active-high power-down request. The request is taken only after it has been synchronised and then seen high on two successive rising edges of the complement CPU reference clock.

When a power-down is accepted, each single-ended output is held low from its next falling edge. Each differential output stops at the next falling edge of its complement phase and parks in a state set by its group's drive-mode bit. When every output has parked, the block reports this and then turns off the VCO and crystal oscillator enables. On release, the oscillators come back at once and tristated differential legs are driven again at once. Each output resumes at its own stop edge only after the PLL reports lock.

All source clocks and the reference clock are treated as levels and sampled by one fast system clock. Each output has a small state machine with three states: run, wait-for-edge and parked. Analog drive strength, the register interface and the PLL are outside this block.

Top module: `pdseq_top`

## Requirements
- R1: Until the synchronised pin has been seen low once, a high level on `pd_pin` is not treated as a power-down. After that, a high level is a power-down request.
- R2: `pd_pin` passes through a two-stage synchroniser, reset to 1, before it can affect anything. A change on the pin cannot alter any output within the two clock cycles that follow it.
- R3: A power-down is accepted only after the synchronised request has stayed high across two rising edges of the sampled `ref_cpu_c`. A request that drops before then resets the count and leaves every output running.
- R4: After acceptance, each single-ended output keeps following its source until that source falls. From then on it is held at 0, so the last high pulse is never cut short.
- R5: After acceptance, each differential output parks on the first falling edge of its complement phase (a rising edge of `df_src`). This happens within 4 periods of its source after acceptance, with true at 1 and complement at 0 at the moment of stopping.
- R6: While parked and power-down is accepted, `df_c_oe` is 0. `df_t_oe` is the inverse of that output's `df_mode` bit: mode 0 drives true high, mode 1 tristates both legs. Bit i of `df_mode` applies to differential output i (0 CPU, 1 SRC, 2 DOT by default).
- R7: `all_parked` is 1 exactly when every output is parked. `vco_en` and `xo_en` go to 0 only in the cycle after power-down is accepted with `all_parked` at 1. They stay 0 only while both of those conditions hold.
- R8: As soon as the accepted power-down drops, both legs of every differential output are driven (true 1, complement 0 while still parked), whatever the state of `pll_lock`.
- R9: A parked output returns to running only when power-down is released, the oscillators are on and `pll_lock` is 1. It does so at its own stop edge: the source falling edge for single-ended outputs, and the complement falling edge for differential outputs.
- R10: If power-down is released while an output is still waiting for its stop edge, the output goes back to running. This holds even when the release and the stop edge fall in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System sampling clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pd_pin | input | 1 | Shared power-good (low) / power-down (high) pin, asynchronous |
| ref_cpu_c | input | 1 | Complement CPU reference clock level |
| se_src | input | NUM_SE | Single-ended source clock levels |
| df_src | input | NUM_DIFF | Differential source clocks, true phase |
| df_mode | input | NUM_DIFF | Per-group park mode: 0 true high, 1 both tristate |
| pll_lock | input | 1 | PLL lock flag |
| se_out | output | NUM_SE | Gated single-ended outputs |
| df_t | output | NUM_DIFF | Differential true leg level |
| df_c | output | NUM_DIFF | Differential complement leg level |
| df_t_oe | output | NUM_DIFF | Drive enable of the true leg |
| df_c_oe | output | NUM_DIFF | Drive enable of the complement leg |
| vco_en | output | 1 | VCO enable |
| xo_en | output | 1 | Crystal oscillator enable |
| all_parked | output | 1 | Every output is parked |

## Verification
Two events can land in the same cycle: the release of an accepted power-down, and an output's detection of its own stop edge. The bench provokes this by sweeping how long the pin stays high over eight successive lengths. The sources have half-periods of 2 to 5 cycles, so some releases land exactly on a lane's stop edge. A behavioural model predicts every output on every cycle. In each such case the lane must return to running instead of parking, and no shortened pulse may appear.

// File: rtl/pdseq_pkg.sv
// Shared types for the power-down sequencer.
package pdseq_pkg;

    // Per-output stop state
    typedef enum logic [1:0] {
        LANE_RUN    = 2'd0,
        LANE_WAIT   = 2'd1,
        LANE_PARKED = 2'd2
    } lane_state_t;

endpackage

// File: rtl/pdseq_sync.sv
// Multi-stage synchroniser for one asynchronous bit.
// Assumes: STAGES >= 1; RST_VAL is the inactive level of the input.
module pdseq_sync #(
    parameter int STAGES  = 2,
    parameter bit RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_i,
    output logic sync_o
);
    logic [STAGES-1:0] chain_q;

    // Shift the asynchronous input through the chain
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chain_q <= {STAGES{RST_VAL}};
        end else if (STAGES == 1) begin
            chain_q[0] <= async_i;
        end else begin
            chain_q <= {chain_q[STAGES-2:0], async_i};
        end
    end

    assign sync_o = chain_q[STAGES-1];
endmodule

// File: rtl/pdseq_ctrl.sv
// Pin role tracking, power-down acceptance and oscillator sequencing.
// Assumes: pin_s is already synchronised; ref_lvl is a clock level sampled here.
module pdseq_ctrl #(
    parameter int ACCEPT_EDGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_s,
    input  logic ref_lvl,
    input  logic all_parked,
    output logic pg_done,
    output logic pd_req,
    output logic pd_acc,
    output logic osc_on
);
    localparam int CW = $clog2(ACCEPT_EDGES + 1);
    localparam logic [CW-1:0] CNT_FULL = CW'(ACCEPT_EDGES);

    logic          ref_q, ref_p;
    logic          ref_rise;
    logic [CW-1:0] acc_cnt;

    assign pd_req   = pg_done & pin_s;
    assign ref_rise = ref_q & ~ref_p;
    assign pd_acc   = (acc_cnt == CNT_FULL);

    // Latch that the power-good phase has ended (pin seen low)
    always_ff @(posedge clk) begin
        if (!rst_n) pg_done <= 1'b0;
        else        pg_done <= pg_done | ~pin_s;
    end

    // Sample the reference clock and keep its previous level for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ref_q <= 1'b0;
            ref_p <= 1'b0;
        end else begin
            ref_q <= ref_lvl;
            ref_p <= ref_q;
        end
    end

    // Count reference rising edges seen while the request stays high
    always_ff @(posedge clk) begin
        if (!rst_n)                              acc_cnt <= '0;
        else if (!pd_req)                        acc_cnt <= '0;
        else if (ref_rise && acc_cnt != CNT_FULL) acc_cnt <= acc_cnt + 1'b1;
    end

    // Oscillators go off only once every output is parked under power-down
    always_ff @(posedge clk) begin
        if (!rst_n) osc_on <= 1'b1;
        else        osc_on <= ~(pd_acc & all_parked);
    end
endmodule

// File: rtl/pdseq_lane.sv
// Stop/restart state machine for one clock output.
// Assumes: src_i is a clock level slow enough to be sampled by clk.
// STOP_ON_RISE=0 stops on a source fall; 1 stops on a source rise
// (the falling edge of the complement phase of a differential output).
module pdseq_lane
    import pdseq_pkg::*;
#(
    parameter bit STOP_ON_RISE = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic src_i,
    input  logic stop_i,
    input  logic resume_i,
    output logic lvl_o,
    output logic parked_o
);
    logic        s_q, s_p;
    logic        edge_hit;
    lane_state_t st;

    assign edge_hit = STOP_ON_RISE ? (s_q & ~s_p) : (s_p & ~s_q);
    assign lvl_o    = s_q;
    assign parked_o = (st == LANE_PARKED);

    // Sample the source and keep one cycle of history
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= 1'b0;
            s_p <= 1'b0;
        end else begin
            s_q <= src_i;
            s_p <= s_q;
        end
    end

    // Move between running, waiting for the stop edge and parked
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st <= LANE_RUN;
        end else begin
            unique case (st)
                LANE_RUN:    if (stop_i) st <= LANE_WAIT;
                LANE_WAIT:   if (!stop_i) st <= LANE_RUN;
                             else if (edge_hit) st <= LANE_PARKED;
                LANE_PARKED: if (!stop_i && resume_i && edge_hit) st <= LANE_RUN;
                default:     st <= LANE_RUN;
            endcase
        end
    end
endmodule

// File: rtl/pdseq_top.sv
// Power-down sequencer for a multi-output clock generator.
// Assumes: every clock input is a level sampled by clk at least 4x its rate;
// bit i of df_mode belongs to differential output i.
module pdseq_top #(
    parameter int NUM_SE       = 3,
    parameter int NUM_DIFF     = 3,
    parameter int SYNC_STAGES  = 2,
    parameter int ACCEPT_EDGES = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                pd_pin,
    input  logic                ref_cpu_c,
    input  logic [NUM_SE-1:0]   se_src,
    input  logic [NUM_DIFF-1:0] df_src,
    input  logic [NUM_DIFF-1:0] df_mode,
    input  logic                pll_lock,
    output logic [NUM_SE-1:0]   se_out,
    output logic [NUM_DIFF-1:0] df_t,
    output logic [NUM_DIFF-1:0] df_c,
    output logic [NUM_DIFF-1:0] df_t_oe,
    output logic [NUM_DIFF-1:0] df_c_oe,
    output logic                vco_en,
    output logic                xo_en,
    output logic                all_parked
);
    localparam int NUM_LANES = NUM_SE + NUM_DIFF;

    logic                 pin_s;
    logic                 pg_done, pd_req, pd_acc, osc_on;
    logic                 resume_ok;
    logic [NUM_LANES-1:0] parked;
    logic [NUM_SE-1:0]    se_lvl;
    logic [NUM_DIFF-1:0]  df_lvl;

    pdseq_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
        .clk(clk), .rst_n(rst_n), .async_i(pd_pin), .sync_o(pin_s)
    );

    pdseq_ctrl #(.ACCEPT_EDGES(ACCEPT_EDGES)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .pin_s(pin_s), .ref_lvl(ref_cpu_c),
        .all_parked(all_parked), .pg_done(pg_done), .pd_req(pd_req),
        .pd_acc(pd_acc), .osc_on(osc_on)
    );

    assign resume_ok  = osc_on & pll_lock;
    assign all_parked = &parked;
    assign vco_en     = osc_on;
    assign xo_en      = osc_on;

    // Single-ended lanes: stop on source fall, park low
    for (genvar gi = 0; gi < NUM_SE; gi++) begin : g_se
        pdseq_lane #(.STOP_ON_RISE(1'b0)) u_lane (
            .clk(clk), .rst_n(rst_n), .src_i(se_src[gi]), .stop_i(pd_acc),
            .resume_i(resume_ok), .lvl_o(se_lvl[gi]), .parked_o(parked[gi])
        );
        assign se_out[gi] = se_lvl[gi] & ~parked[gi];
    end

    // Differential lanes: stop on complement fall, park per mode bit
    for (genvar gd = 0; gd < NUM_DIFF; gd++) begin : g_df
        pdseq_lane #(.STOP_ON_RISE(1'b1)) u_lane (
            .clk(clk), .rst_n(rst_n), .src_i(df_src[gd]), .stop_i(pd_acc),
            .resume_i(resume_ok), .lvl_o(df_lvl[gd]), .parked_o(parked[NUM_SE+gd])
        );
        assign df_t[gd]    = parked[NUM_SE+gd] | df_lvl[gd];
        assign df_c[gd]    = ~parked[NUM_SE+gd] & ~df_lvl[gd];
        assign df_t_oe[gd] = ~(parked[NUM_SE+gd] & pd_acc & df_mode[gd]);
        assign df_c_oe[gd] = ~(parked[NUM_SE+gd] & pd_acc);
    end
endmodule

// File: rtl/pdseq_chk.sv
// Property checker for pdseq_top, attached by bind.
module pdseq_chk #(
    parameter int NUM_SE   = 3,
    parameter int NUM_DIFF = 3
) (
    input logic                clk,
    input logic                rst_n,
    input logic                pg_done,
    input logic                pd_req,
    input logic                pd_acc,
    input logic                all_parked,
    input logic                vco_en,
    input logic                xo_en,
    input logic [NUM_SE-1:0]   se_out,
    input logic [NUM_DIFF-1:0] df_t_oe,
    input logic [NUM_DIFF-1:0] df_c_oe,
    input logic [NUM_DIFF-1:0] df_mode
);
    AST_NO_PD_BEFORE_PG: assert property (@(posedge clk) disable iff (!rst_n)
        !pg_done |-> !pd_acc); // R1

    AST_ACCEPT_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pd_acc) |-> $past(pd_req)); // R3

    AST_LAST_PARK_NO_RUNT: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(all_parked) |-> ($past(se_out) == '0)); // R4

    AST_PARKED_SE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        all_parked |-> (se_out == '0)); // R4

    AST_PARK_MODE: assert property (@(posedge clk) disable iff (!rst_n)
        (all_parked && pd_acc) |-> (df_c_oe == '0 && df_t_oe == ~df_mode)); // R6

    AST_OSC_OFF_PARKED: assert property (@(posedge clk) disable iff (!rst_n)
        !vco_en |-> (all_parked && !xo_en)); // R7

    AST_OSC_OFF_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(vco_en) |-> $past(all_parked && pd_acc)); // R7

    AST_RELEASE_DRIVES: assert property (@(posedge clk) disable iff (!rst_n)
        !pd_acc |-> (&df_t_oe && &df_c_oe)); // R8
endmodule

bind pdseq_top pdseq_chk #(.NUM_SE(NUM_SE), .NUM_DIFF(NUM_DIFF)) u_pdseq_chk (
    .clk(clk), .rst_n(rst_n), .pg_done(u_ctrl.pg_done), .pd_req(u_ctrl.pd_req),
    .pd_acc(u_ctrl.pd_acc), .all_parked(all_parked), .vco_en(vco_en), .xo_en(xo_en),
    .se_out(se_out), .df_t_oe(df_t_oe), .df_c_oe(df_c_oe), .df_mode(df_mode)
);

// File: tb/test_pdseq_top.sv
// Bench for pdseq_top: behavioural model compared on every cycle plus directed checks.
module test_pdseq_top;
    localparam int NSE = 3;
    localparam int NDF = 3;
    localparam int NL  = NSE + NDF;
    localparam int HP [NL] = '{2, 3, 5, 2, 3, 4};
    localparam int REF_HP = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic pd_pin = 1'b1;
    logic ref_cpu_c = 1'b0;
    logic [NSE-1:0] se_src = '0;
    logic [NDF-1:0] df_src = '0;
    logic [NDF-1:0] df_mode = 3'b010;
    logic pll_lock = 1'b1;
    logic [NSE-1:0] se_out;
    logic [NDF-1:0] df_t, df_c, df_t_oe, df_c_oe;
    logic vco_en, xo_en, all_parked;

    int n_cmp = 0;
    int n_bad = 0;
    int cyc = 0;
    int tick = 0;
    string phase = "R1";

    pdseq_top i_pdseq_top (
        .clk(clk), .rst_n(rst_n), .pd_pin(pd_pin), .ref_cpu_c(ref_cpu_c),
        .se_src(se_src), .df_src(df_src), .df_mode(df_mode), .pll_lock(pll_lock),
        .se_out(se_out), .df_t(df_t), .df_c(df_c), .df_t_oe(df_t_oe), .df_c_oe(df_c_oe),
        .vco_en(vco_en), .xo_en(xo_en), .all_parked(all_parked)
    );

    always #4 clk = ~clk;

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s (phase %s) cycle %0d: actual %0h expected %0h",
                     req, what, phase, cyc, act, exp);
        end
    endtask

    // Behavioural model state
    int m_p1, m_p2, m_pg, m_r1, m_r2, m_cnt, m_osc;
    int m_sq [NL];
    int m_sp [NL];
    int m_st [NL]; // 0 running, 1 waiting, 2 parked

    always @(posedge clk) begin
        if (!rst_n) begin
            m_p1 = 1; m_p2 = 1; m_pg = 0; m_r1 = 0; m_r2 = 0; m_cnt = 0; m_osc = 1;
            for (int k = 0; k < NL; k++) begin m_sq[k] = 0; m_sp[k] = 0; m_st[k] = 0; end
        end else begin
            int req, acc, rise, allp, ok;
            req  = (m_pg != 0 && m_p2 != 0) ? 1 : 0;
            acc  = (m_cnt == 2) ? 1 : 0;
            rise = (m_r1 != 0 && m_r2 == 0) ? 1 : 0;
            ok   = (m_osc != 0 && pll_lock) ? 1 : 0;
            allp = 1;
            for (int k = 0; k < NL; k++) if (m_st[k] != 2) allp = 0;
            for (int k = 0; k < NL; k++) begin
                int e;
                e = (k >= NSE) ? int'(m_sq[k] == 1 && m_sp[k] == 0)
                               : int'(m_sp[k] == 1 && m_sq[k] == 0);
                if (m_st[k] == 0) begin
                    if (acc != 0) m_st[k] = 1;
                end else if (m_st[k] == 1) begin
                    if (acc == 0) m_st[k] = 0;
                    else if (e != 0) m_st[k] = 2;
                end else begin
                    if (acc == 0 && ok != 0 && e != 0) m_st[k] = 0;
                end
            end
            if (req == 0) m_cnt = 0;
            else if (rise != 0 && m_cnt < 2) m_cnt++;
            m_osc = (acc != 0 && allp != 0) ? 0 : 1;
            if (m_p2 == 0) m_pg = 1;
            m_p2 = m_p1; m_p1 = int'(pd_pin);
            m_r2 = m_r1; m_r1 = int'(ref_cpu_c);
            for (int k = 0; k < NL; k++) begin
                m_sp[k] = m_sq[k];
                m_sq[k] = (k < NSE) ? int'(se_src[k]) : int'(df_src[k-NSE]);
            end
        end
    end

    int acc_prev = 0;
    int acc_cyc = 0;
    logic [NDF-1:0] coe_prev = '1;

    // Compare every output with the model, then advance the sources
    always @(negedge clk) begin
        int acc, allp, e_se, e_t, e_c, e_toe, e_coe;
        cyc++;
        acc = (m_cnt == 2) ? 1 : 0;
        allp = 1; e_se = 0; e_t = 0; e_c = 0; e_toe = 0; e_coe = 0;
        for (int k = 0; k < NL; k++) if (m_st[k] != 2) allp = 0;
        for (int k = 0; k < NSE; k++)
            if (m_st[k] != 2 && m_sq[k] != 0) e_se |= (1 << k);
        for (int j = 0; j < NDF; j++) begin
            int pk;
            pk = (m_st[NSE+j] == 2) ? 1 : 0;
            if (pk != 0 || m_sq[NSE+j] != 0) e_t |= (1 << j);
            if (pk == 0 && m_sq[NSE+j] == 0) e_c |= (1 << j);
            if (!(pk != 0 && acc != 0 && df_mode[j])) e_toe |= (1 << j);
            if (!(pk != 0 && acc != 0)) e_coe |= (1 << j);
        end
        if (rst_n) begin
            chk("R4", "se_out", int'(se_out), e_se);
            chk("R5", "df_t", int'(df_t), e_t);
            chk("R5", "df_c", int'(df_c), e_c);
            chk("R6", "df_t_oe", int'(df_t_oe), e_toe);
            chk("R8", "df_c_oe", int'(df_c_oe), e_coe);
            chk("R7", "vco_en", int'(vco_en), m_osc);
            chk("R7", "xo_en", int'(xo_en), m_osc);
            chk("R7", "all_parked", int'(all_parked), allp);
            if (acc != 0 && acc_prev == 0) acc_cyc = cyc;
            for (int j = 0; j < NDF; j++)
                if (coe_prev[j] && !df_c_oe[j])
                    chk("R5", "park within 4 periods", int'(cyc - acc_cyc <= 8 * HP[NSE+j]), 1);
        end
        acc_prev = acc;
        coe_prev = df_c_oe;
        tick++;
        for (int k = 0; k < NSE; k++) se_src[k] = ((tick / HP[k]) % 2) != 0;
        for (int j = 0; j < NDF; j++) df_src[j] = ((tick / HP[NSE+j]) % 2) != 0;
        ref_cpu_c = ((tick / REF_HP) % 2) != 0;
    end

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic finish_run;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    // Watchdog: a hung run is a failed check
    initial begin
        repeat (150000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL watchdog expired at cycle %0d: actual running expected done", cyc);
        finish_run();
    end

    initial begin
        bit stop_seen;
        wait_cyc(3);
        chk("R7", "reset vco_en", int'(vco_en), 1);
        chk("R7", "reset all_parked", int'(all_parked), 0);
        chk("R8", "reset df_c_oe", int'(df_c_oe), 7);
        @(negedge clk); rst_n = 1'b1;

        // R1: pin high before power-good must not stop anything
        phase = "R1";
        wait_cyc(40);
        chk("R1", "no park before power-good", int'(all_parked), 0);
        chk("R1", "osc on before power-good", int'(vco_en), 1);
        pd_pin = 1'b0;
        wait_cyc(20);

        // R2/R4/R6/R7: full power-down with mode 010
        phase = "R6";
        pd_pin = 1'b1;
        wait_cyc(2);
        chk("R2", "no effect within sync delay", int'(df_c_oe), 7);
        wait_cyc(60);
        chk("R7", "all parked", int'(all_parked), 1);
        chk("R7", "vco off", int'(vco_en), 0);
        chk("R7", "xo off", int'(xo_en), 0);
        chk("R4", "se parked low", int'(se_out), 0);
        chk("R6", "true oe mode 010", int'(df_t_oe), 3'b101);
        chk("R6", "comp oe parked", int'(df_c_oe), 0);

        // R8/R9: release with lock low
        phase = "R8";
        pll_lock = 1'b0;
        pd_pin = 1'b0;
        wait_cyc(5);
        chk("R8", "true legs driven", int'(df_t_oe), 7);
        chk("R8", "comp legs driven", int'(df_c_oe), 7);
        chk("R8", "true level high", int'(df_t), 7);
        chk("R8", "comp level low", int'(df_c), 0);
        chk("R7", "osc back on", int'(vco_en), 1);
        phase = "R9";
        wait_cyc(10);
        chk("R9", "held parked without lock", int'(all_parked), 1);
        pll_lock = 1'b1;
        wait_cyc(30);
        chk("R9", "resumed after lock", int'(all_parked), 0);

        // R10: release swept against stop edges
        phase = "R10";
        for (int d = 0; d < 8; d++) begin
            pd_pin = 1'b1;
            wait_cyc(9 + d);
            pd_pin = 1'b0;
            wait_cyc(40);
            chk("R10", "running after release", int'(all_parked), 0);
            chk("R10", "osc on after release", int'(vco_en), 1);
        end

        // R3: one-cycle pulse must not be accepted
        phase = "R3";
        stop_seen = 1'b0;
        pd_pin = 1'b1;
        @(negedge clk);
        pd_pin = 1'b0;
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            if (df_c_oe != 3'b111 || !vco_en) stop_seen = 1'b1;
        end
        chk("R3", "short pulse ignored", int'(stop_seen), 0);

        // R6: second mode pattern 101
        phase = "R6";
        df_mode = 3'b101;
        pd_pin = 1'b1;
        wait_cyc(60);
        chk("R6", "true oe mode 101", int'(df_t_oe), 3'b010);
        chk("R6", "true level mode 101", int'(df_t & df_t_oe), 3'b010);
        pd_pin = 1'b0;
        wait_cyc(40);
        chk("R9", "final resume", int'(all_parked), 0);
        finish_run();
    end
endmodule